// File: doc/BRIEF.md
# Audio DSP Peripheral Interrupt and DMA Register Slice

This block is the slice of an audio signal processor's peripheral address space that deals with frame interrupts, core idling and the DMA register window. The core drives a 24-bit peripheral bus with separate read and write strobes. The block decodes that bus against a small set of fixed addresses. Read data is registered and appears one clock after the read strobe.

The interrupt status word holds two kinds of bit. The abort-frame and start-frame bits are latched and are set by event inputs. The end-of-list bit comes from a flag that a DMA event input raises. Software clears any of these by writing ones to the status address. A write with bit 0 set to the idle address parks the core: instruction-step strobes are then ignored until an event input arrives. Four consecutive addresses are forwarded as register reads and writes to an external DMA engine.

The block also models the DMA engine's auto-stop. It counts the instruction steps taken while the engine reports that it is running. After a parameterised number of steps (three by default) it pulses a retire output, which tells the engine to clear its running flag and set its stopped flag.

Top module: `dsp_periph_regs`

## Requirements
- R1: After reset, read data is 0x000000, the idle output is 0, the retire pulse is 0 and the status word reads 0x000000.
- R2: A read of 0xFFFFC5 returns the status word one clock after the read strobe. In that word, bit 0 is abort-frame, bit 1 is start-frame, and bit 7 is 1 whenever the end-of-list flag is set. All other bits are 0.
- R3: A write to 0xFFFFC5 clears each latched bit (bit 0 or bit 1) that is 1 in the write data and leaves the other bits unchanged.
- R4: A write to 0xFFFFC5 with data bit 7 set clears the end-of-list flag. With data bit 7 clear, the flag is unchanged.
- R5: When an event input and a clearing write to the same status bit fall in the same cycle, the bit ends up set.
- R6: A start-frame event sets only status bit 1, and an abort-frame event sets only status bit 0.
- R7: A write to 0xFFFFC4 with data bit 0 set raises the idle output from the next clock. A write to 0xFFFFC4 with data bit 0 clear leaves the idle output unchanged.
- R8: Any event input (start-frame, abort-frame or end-of-list) lowers the idle output from the next clock.
- R9: While the idle output is high, step strobes are not counted toward the DMA retire count.
- R10: A write to 0xFFFFD4 through 0xFFFFD7 raises the DMA write strobe in the same cycle. It drives register select = address bits 1:0 (0 = next block, 1 = start block, 2 = control, 3 = configuration) and passes the write data through. Writes to other addresses leave the DMA write strobe low.
- R11: A read of 0xFFFFD4 through 0xFFFFD7 raises the DMA read strobe with the same register select, and returns the DMA read data one clock later.
- R12: A read of 0xFFFFB3 returns 0x000000. A read of any other unmapped address returns 0x0ABABA.
- R13: While the DMA running input is high, the third counted step strobe produces a one-cycle retire pulse on the following clock and restarts the count. While the running input is low, the count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pbus_addr | input | 24 | Peripheral bus address |
| pbus_wr | input | 1 | Peripheral write strobe |
| pbus_rd | input | 1 | Peripheral read strobe |
| pbus_wdata | input | 24 | Peripheral write data |
| pbus_rdata | output | 24 | Registered read data |
| step_strobe | input | 1 | One pulse per executed instruction |
| core_idle | output | 1 | Idle request to the core |
| frame_start_evt | input | 1 | Start-of-frame event |
| frame_abort_evt | input | 1 | Abort-frame event |
| dma_eol_evt | input | 1 | DMA end-of-list event |
| dma_running | input | 1 | DMA engine reports running |
| dma_retire | output | 1 | Pulse: move DMA from running to stopped |
| dma_sel | output | 2 | DMA register select |
| dma_wr | output | 1 | DMA register write strobe |
| dma_rd | output | 1 | DMA register read strobe |
| dma_wdata | output | 24 | DMA register write data |
| dma_rdata | input | 24 | DMA register read data |

## Verification
Two pairs of actions can land in the same cycle: a status-clearing write and a set event for the same bit, and an idle request together with an event that should wake the core. The bench drives a start-frame event and a write-one to bit 1 on the same clock, and does the same with the end-of-list event and bit 7. It then reads the status back and expects the bit to still be set. Steps issued while idle are checked by watching the retire pulse: it must stay low, and only the three steps counted after the wake may produce it.

// File: rtl/dsp_periph_pkg.sv
package dsp_periph_pkg;
   typedef enum logic [2:0] {
      PSEL_NONE   = 3'd0,
      PSEL_STATUS = 3'd1,
      PSEL_IDLE   = 3'd2,
      PSEL_DMA    = 3'd3,
      PSEL_ZERO   = 3'd4
   } psel_e;

   localparam int ABORT_POS = 0;
   localparam int START_POS = 1;
   localparam int EOL_POS   = 7;
   localparam int LAT_CNT   = 2;
endpackage

// File: rtl/dpr_decode.sv
module dpr_decode
   import dsp_periph_pkg::*;
#(
   parameter int              ADDR_W      = 24,
   parameter logic [23:0]     STATUS_ADDR = 24'hFFFFC5,
   parameter logic [23:0]     IDLE_ADDR   = 24'hFFFFC4,
   parameter logic [23:0]     DMA_BASE    = 24'hFFFFD4,
   parameter logic [23:0]     ZERO_ADDR   = 24'hFFFFB3
) (
   input  logic [ADDR_W-1:0] addr,
   output psel_e             psel,
   output logic [1:0]        dma_idx
);
   initial begin
      if (ADDR_W < 3 || ADDR_W > 24) $error("dpr_decode: ADDR_W out of range");
      if (DMA_BASE[1:0] != 2'b00) $error("dpr_decode: DMA_BASE must be 4-aligned");
   end

   always_comb begin
      psel    = PSEL_NONE;
      dma_idx = addr[1:0];
      if (addr == STATUS_ADDR[ADDR_W-1:0])
         psel = PSEL_STATUS;
      else if (addr == IDLE_ADDR[ADDR_W-1:0])
         psel = PSEL_IDLE;
      else if (addr == ZERO_ADDR[ADDR_W-1:0])
         psel = PSEL_ZERO;
      else if (addr[ADDR_W-1:2] == DMA_BASE[ADDR_W-1:2])
         psel = PSEL_DMA;
   end
endmodule

// File: rtl/dpr_irq_status.sv
module dpr_irq_status
   import dsp_periph_pkg::*;
#(
   parameter int DATA_W  = 24,
   parameter int LAT_W   = LAT_CNT,
   parameter int EOL_BIT = EOL_POS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LAT_W-1:0]  evt_vec,
   input  logic              eol_evt,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] clr_data,
   output logic [DATA_W-1:0] status_word
);
   initial begin
      if (LAT_W < 1 || LAT_W > EOL_BIT) $error("dpr_irq_status: LAT_W must be 1..EOL_BIT");
      if (EOL_BIT >= DATA_W) $error("dpr_irq_status: EOL_BIT outside data word");
   end

   logic [LAT_W-1:0] lat_q;
   logic             eol_q;

   for (genvar g = 0; g < LAT_W; g++) begin : g_lat
      always_ff @(posedge clk) begin
         if (!rst_n)
            lat_q[g] <= 1'b0;
         else if (evt_vec[g])
            lat_q[g] <= 1'b1;
         else if (clr_we && clr_data[g])
            lat_q[g] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         eol_q <= 1'b0;
      else if (eol_evt)
         eol_q <= 1'b1;
      else if (clr_we && clr_data[EOL_BIT])
         eol_q <= 1'b0;
   end

   always_comb begin
      status_word                = '0;
      status_word[LAT_W-1:0]     = lat_q;
      status_word[EOL_BIT]       = eol_q;
   end

   // R5
   evt_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vec != '0) |=> ((lat_q & $past(evt_vec)) == $past(evt_vec)));

   // R4
   eol_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_data[EOL_BIT] && !eol_evt) |=> !eol_q);

   // R5
   eol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eol_evt |=> eol_q);
endmodule

// File: rtl/dpr_dma_timer.sv
module dpr_dma_timer #(
   parameter int RETIRE_STEPS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_ok,
   input  logic running,
   output logic retire
);
   localparam int CNT_W = (RETIRE_STEPS < 2) ? 1 : $clog2(RETIRE_STEPS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RETIRE_STEPS - 1);

   initial begin
      if (RETIRE_STEPS < 1) $error("dpr_dma_timer: RETIRE_STEPS must be >= 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         retire <= 1'b0;
      end else begin
         retire <= 1'b0;
         if (!running) begin
            cnt_q <= '0;
         end else if (step_ok) begin
            if (cnt_q == LAST) begin
               cnt_q  <= '0;
               retire <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R13
   retire_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> ($past(running) && $past(step_ok)));

   // R13
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R13
   retire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && RETIRE_STEPS > 1) |=> !retire);
endmodule

// File: rtl/dsp_periph_regs.sv
module dsp_periph_regs
   import dsp_periph_pkg::*;
#(
   parameter int          ADDR_W       = 24,
   parameter int          DATA_W       = 24,
   parameter int          RETIRE_STEPS = 3,
   parameter logic [23:0] FILL_VALUE   = 24'h0ABABA,
   parameter logic [23:0] STATUS_ADDR  = 24'hFFFFC5,
   parameter logic [23:0] IDLE_ADDR    = 24'hFFFFC4,
   parameter logic [23:0] DMA_BASE     = 24'hFFFFD4,
   parameter logic [23:0] ZERO_ADDR    = 24'hFFFFB3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pbus_addr,
   input  logic              pbus_wr,
   input  logic              pbus_rd,
   input  logic [DATA_W-1:0] pbus_wdata,
   output logic [DATA_W-1:0] pbus_rdata,
   input  logic              step_strobe,
   output logic              core_idle,
   input  logic              frame_start_evt,
   input  logic              frame_abort_evt,
   input  logic              dma_eol_evt,
   input  logic              dma_running,
   output logic              dma_retire,
   output logic [1:0]        dma_sel,
   output logic              dma_wr,
   output logic              dma_rd,
   output logic [DATA_W-1:0] dma_wdata,
   input  logic [DATA_W-1:0] dma_rdata
);
   initial begin
      if (DATA_W < 8 || DATA_W > 24) $error("dsp_periph_regs: DATA_W must be 8..24");
   end

   psel_e             psel;
   logic [1:0]        dma_idx;
   logic [DATA_W-1:0] status_word;
   logic [LAT_CNT-1:0] lat_evt;
   logic              any_evt;
   logic              step_ok;

   dpr_decode #(
      .ADDR_W      (ADDR_W),
      .STATUS_ADDR (STATUS_ADDR),
      .IDLE_ADDR   (IDLE_ADDR),
      .DMA_BASE    (DMA_BASE),
      .ZERO_ADDR   (ZERO_ADDR)
   ) u_decode (
      .addr    (pbus_addr),
      .psel    (psel),
      .dma_idx (dma_idx)
   );

   always_comb begin
      lat_evt            = '0;
      lat_evt[ABORT_POS] = frame_abort_evt;
      lat_evt[START_POS] = frame_start_evt;
   end

   dpr_irq_status #(
      .DATA_W  (DATA_W),
      .LAT_W   (LAT_CNT),
      .EOL_BIT (EOL_POS)
   ) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_vec     (lat_evt),
      .eol_evt     (dma_eol_evt),
      .clr_we      (pbus_wr && (psel == PSEL_STATUS)),
      .clr_data    (pbus_wdata),
      .status_word (status_word)
   );

   assign any_evt = frame_start_evt | frame_abort_evt | dma_eol_evt;
   assign step_ok = step_strobe & ~core_idle;

   always_ff @(posedge clk) begin
      if (!rst_n)
         core_idle <= 1'b0;
      else if (any_evt)
         core_idle <= 1'b0;
      else if (pbus_wr && (psel == PSEL_IDLE) && pbus_wdata[0])
         core_idle <= 1'b1;
   end

   dpr_dma_timer #(
      .RETIRE_STEPS (RETIRE_STEPS)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_ok (step_ok),
      .running (dma_running),
      .retire  (dma_retire)
   );

   assign dma_sel   = dma_idx;
   assign dma_wr    = pbus_wr && (psel == PSEL_DMA);
   assign dma_rd    = pbus_rd && (psel == PSEL_DMA);
   assign dma_wdata = pbus_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pbus_rdata <= '0;
      end else if (pbus_rd) begin
         case (psel)
            PSEL_STATUS: pbus_rdata <= status_word;
            PSEL_DMA:    pbus_rdata <= dma_rdata;
            PSEL_ZERO:   pbus_rdata <= '0;
            default:     pbus_rdata <= FILL_VALUE[DATA_W-1:0];
         endcase
      end
   end

   // R7
   idle_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_idle) |-> $past(pbus_wr && (pbus_addr == IDLE_ADDR[ADDR_W-1:0]) && pbus_wdata[0]));

   // R8
   idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start_evt || frame_abort_evt || dma_eol_evt) |=> !core_idle);

   // R10
   dma_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_wr |-> (pbus_addr[ADDR_W-1:2] == DMA_BASE[ADDR_W-1:2]));
endmodule

// File: tb/dsp_periph_regs_bench.sv
module dsp_periph_regs_bench;
   typedef struct packed {
      logic        wr;
      logic [23:0] addr;
      logic [23:0] data;
      logic [23:0] exp;
   } vec_t;

   // reads: exp is read data; writes to idle address: exp[0] is expected idle
   localparam vec_t VECS [0:8] = '{
      '{1'b0, 24'hFFFFB3, 24'h0, 24'h000000},   // R12
      '{1'b0, 24'h000000, 24'h0, 24'h0ABABA},   // R12
      '{1'b0, 24'hFFFFC3, 24'h0, 24'h0ABABA},   // R12
      '{1'b0, 24'hFFFFD8, 24'h0, 24'h0ABABA},   // R12
      '{1'b0, 24'hFFFFD4, 24'h0, 24'h5A5A00},   // R11
      '{1'b0, 24'hFFFFD6, 24'h0, 24'h5A5A02},   // R11
      '{1'b0, 24'hFFFFD7, 24'h0, 24'h5A5A03},   // R11
      '{1'b0, 24'hFFFFC5, 24'h0, 24'h000000},   // R2
      '{1'b1, 24'hFFFFC4, 24'h0, 24'h000000}    // R7
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] pbus_addr = '0;
   logic        pbus_wr = 1'b0;
   logic        pbus_rd = 1'b0;
   logic [23:0] pbus_wdata = '0;
   logic [23:0] pbus_rdata;
   logic        step_strobe = 1'b0;
   logic        core_idle;
   logic        frame_start_evt = 1'b0;
   logic        frame_abort_evt = 1'b0;
   logic        dma_eol_evt = 1'b0;
   logic        dma_running = 1'b0;
   logic        dma_retire;
   logic [1:0]  dma_sel;
   logic        dma_wr;
   logic        dma_rd;
   logic [23:0] dma_wdata;
   logic [23:0] dma_rdata;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #10 clk = ~clk;

   assign dma_rdata = 24'h5A5A00 | {22'b0, dma_sel};

   dsp_periph_regs u_dsp_periph_regs (
      .clk (clk), .rst_n (rst_n),
      .pbus_addr (pbus_addr), .pbus_wr (pbus_wr), .pbus_rd (pbus_rd),
      .pbus_wdata (pbus_wdata), .pbus_rdata (pbus_rdata),
      .step_strobe (step_strobe), .core_idle (core_idle),
      .frame_start_evt (frame_start_evt), .frame_abort_evt (frame_abort_evt),
      .dma_eol_evt (dma_eol_evt), .dma_running (dma_running),
      .dma_retire (dma_retire), .dma_sel (dma_sel), .dma_wr (dma_wr),
      .dma_rd (dma_rd), .dma_wdata (dma_wdata), .dma_rdata (dma_rdata)
   );

   task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%06h expected=%06h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [23:0] a, input logic [23:0] d);
      pbus_wr = 1'b1; pbus_addr = a; pbus_wdata = d;
      @(negedge clk);
      pbus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [23:0] a, output logic [23:0] d);
      pbus_rd = 1'b1; pbus_addr = a;
      @(negedge clk);
      pbus_rd = 1'b0;
      d = pbus_rdata;
   endtask

   task automatic pulse_evt(input int which);
      if (which == 0) frame_start_evt = 1'b1;
      if (which == 1) frame_abort_evt = 1'b1;
      if (which == 2) dma_eol_evt = 1'b1;
      @(negedge clk);
      frame_start_evt = 1'b0; frame_abort_evt = 1'b0; dma_eol_evt = 1'b0;
   endtask

   task automatic step_once();
      step_strobe = 1'b1;
      @(negedge clk);
      step_strobe = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [23:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rdata", pbus_rdata, 24'h0);
      chk("R1 idle", {23'b0, core_idle}, 24'h0);
      chk("R1 retire", {23'b0, dma_retire}, 24'h0);

      // table walk: R2 R7 R11 R12
      for (int i = 0; i < 9; i++) begin
         if (VECS[i].wr) begin
            bus_write(VECS[i].addr, VECS[i].data);
            chk($sformatf("table[%0d] R7 idle", i), {23'b0, core_idle}, VECS[i].exp);
         end else begin
            bus_read(VECS[i].addr, rd);
            chk($sformatf("table[%0d] R2/R11/R12 read", i), rd, VECS[i].exp);
         end
      end

      // R11 read strobe and select
      pbus_rd = 1'b1; pbus_addr = 24'hFFFFD5; #1;
      chk("R11 dma_rd", {23'b0, dma_rd}, 24'h1);
      chk("R11 dma_sel", {22'b0, dma_sel}, 24'h1);
      @(negedge clk); pbus_rd = 1'b0;
      chk("R11 rdata", pbus_rdata, 24'h5A5A01);

      // R6 R2 event setting
      pulse_evt(0);
      bus_read(24'hFFFFC5, rd); chk("R6 start bit", rd, 24'h000002);
      pulse_evt(1);
      bus_read(24'hFFFFC5, rd); chk("R6 abort bit", rd, 24'h000003);
      pulse_evt(2);
      bus_read(24'hFFFFC5, rd); chk("R2 eol merge", rd, 24'h000083);

      // R3 R4 write-one-to-clear
      bus_write(24'hFFFFC5, 24'h000001);
      bus_read(24'hFFFFC5, rd); chk("R3 clear bit0", rd, 24'h000082);
      bus_write(24'hFFFFC5, 24'h000080);
      bus_read(24'hFFFFC5, rd); chk("R4 clear eol", rd, 24'h000002);
      bus_write(24'hFFFFC5, 24'h000002);
      bus_read(24'hFFFFC5, rd); chk("R3 clear bit1", rd, 24'h000000);

      // R5 same-cycle set and clear
      frame_start_evt = 1'b1;
      bus_write(24'hFFFFC5, 24'h000002);
      frame_start_evt = 1'b0;
      bus_read(24'hFFFFC5, rd); chk("R5 start wins", rd, 24'h000002);
      dma_eol_evt = 1'b1;
      bus_write(24'hFFFFC5, 24'h000080);
      dma_eol_evt = 1'b0;
      bus_read(24'hFFFFC5, rd); chk("R5 eol wins", rd, 24'h000082);
      bus_write(24'hFFFFC5, 24'h000002);
      bus_read(24'hFFFFC5, rd); chk("R4 eol kept when bit7 clear", rd, 24'h000080);
      bus_write(24'hFFFFC5, 24'hFFFFFF);
      bus_read(24'hFFFFC5, rd); chk("R3 clear all", rd, 24'h000000);

      // R10 DMA write passthrough
      pbus_wr = 1'b1; pbus_addr = 24'hFFFFD5; pbus_wdata = 24'h123456; #1;
      chk("R10 dma_wr", {23'b0, dma_wr}, 24'h1);
      chk("R10 dma_sel", {22'b0, dma_sel}, 24'h1);
      chk("R10 dma_wdata", dma_wdata, 24'h123456);
      chk("R10 dma_rd low", {23'b0, dma_rd}, 24'h0);
      pbus_addr = 24'hFFFFC6; #1;
      chk("R10 no dma_wr elsewhere", {23'b0, dma_wr}, 24'h0);
      @(negedge clk); pbus_wr = 1'b0;

      // R7 idle, R9 steps ignored while idle
      bus_write(24'hFFFFC4, 24'h000001);
      chk("R7 idle set", {23'b0, core_idle}, 24'h1);
      dma_running = 1'b1;
      for (int k = 0; k < 4; k++) begin
         step_once();
         chk("R9 no retire while idle", {23'b0, dma_retire}, 24'h0);
      end
      // R8 wake by abort event
      pulse_evt(1);
      chk("R8 wake on abort", {23'b0, core_idle}, 24'h0);
      // R13 retire after third step
      step_once(); chk("R13 step1", {23'b0, dma_retire}, 24'h0);
      step_once(); chk("R13 step2", {23'b0, dma_retire}, 24'h0);
      step_once(); chk("R13 step3 retire", {23'b0, dma_retire}, 24'h1);
      @(negedge clk); chk("R13 pulse one cycle", {23'b0, dma_retire}, 24'h0);
      // R13 count held while not running
      step_once(); step_once();
      dma_running = 1'b0;
      step_once(); step_once();
      dma_running = 1'b1;
      step_once(); chk("R13 count restarted", {23'b0, dma_retire}, 24'h0);
      step_once(); chk("R13 second", {23'b0, dma_retire}, 24'h0);
      step_once(); chk("R13 third again", {23'b0, dma_retire}, 24'h1);
      dma_running = 1'b0;

      // R8 wake by start event
      bus_write(24'hFFFFC4, 24'h000003);
      chk("R7 idle set again", {23'b0, core_idle}, 24'h1);
      pulse_evt(0);
      chk("R8 wake on start", {23'b0, core_idle}, 24'h0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule